// File: doc/BRIEF.md
# Clock Lane Low-Power Entry Controller

This block decides, cycle by cycle, whether the clock lane of a serial display link keeps high-speed clocking or is parked in the low-power state. It drives the transitions in both directions without any software action. Two configuration bits must both be set for the automatic behaviour to run. When either is clear, the lane stays in high-speed operation.

In command operation, the lane is parked whenever no high-speed packet waits. In video operation, the decision depends on the number of inactive byte-clock cycles left in the current blanking region. The lane is parked only when that number covers both programmed transition times, the high-speed to low-power time and the low-power to high-speed time. The lane is brought back early enough that pixel and sync traffic is never delayed.

Downstream logic watches two outputs. A low-power request follows the lane's parked or parking condition. A ready flag tells the packet path when high-speed data may be sent.

Top module: `clk_lane_lp_ctrl`

## Requirements
- R1: After a synchronous reset, `hs_ready` is 1 and `lp_req` is 0.
- R2: While `cfg_enable` or `cfg_auto` is 0, a controller in high-speed operation stays there, whatever the other inputs are.
- R3: In command operation (`mode_video`=0), with both enables set and `hs_pending`=0, the controller starts leaving high-speed at the next clock edge. `lp_req` becomes 1 and `hs_ready` becomes 0.
- R4: In command operation, while `hs_pending`=1, the controller stays in high-speed operation.
- R5: In video operation (`mode_video`=1), low-power entry starts only if `blank_left` is nonzero and `blank_left` >= `cfg_hs2lp` + `cfg_lp2hs`, with the sum taken at full precision. `hs_pending` has no effect on this decision.
- R6: The high-speed to low-power transition lasts max(`cfg_hs2lp`,1) cycles, with `lp_req`=1 and `hs_ready`=0. The lane then rests in low power with `lp_req`=1. During the transition, a wake condition is not acted on.
- R7: In command operation, `hs_pending`=1 during the low-power rest starts the return. `lp_req` drops at the next edge, and `hs_ready` stays 0 for max(`cfg_lp2hs`,1) cycles, then becomes 1.
- R8: In video operation, the low-power rest continues while `blank_left` > `cfg_lp2hs`. Once `blank_left` <= `cfg_lp2hs`, the return starts at the next edge.
- R9: Clearing either enable during the low-power rest starts the return, and the controller then stays in high-speed operation.
- R10: `hs_ready` and `lp_req` are never 1 together. During the return transition, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-speed byte clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Clock-control enable |
| cfg_auto | input | 1 | Automatic clock-lane control enable |
| cfg_hs2lp | input | TW | High-speed to low-power transition time, in byte-clock cycles |
| cfg_lp2hs | input | TW | Low-power to high-speed transition time, in byte-clock cycles |
| mode_video | input | 1 | 1 = video operation, 0 = command operation |
| hs_pending | input | 1 | A high-speed packet waits to be sent |
| blank_left | input | BW | Inactive byte-clock cycles left in the current video region |
| lp_req | output | 1 | Clock lane low-power request |
| hs_ready | output | 1 | High-speed data may be sent |

## Verification
A vector table sweeps the entry decision over several cases:
- both enable bits, each cleared alone;
- command operation with and without a waiting packet;
- video blanking counts just below, at, and above the sum of the two transition times, including zero times and the widest times.

Each vector separates an off-by-one or truncated-sum comparison from the correct one. Directed sequences then time whole low-power episodes, which pins down the following:
- the transition lengths, including the minimum of one cycle;
- the rule that wake requests are not acted on mid-transition;
- the video wake threshold;
- the forced return when an enable bit is cleared.

// File: rtl/clk_lane_pkg.sv
package clk_lane_pkg;

    typedef enum logic [1:0] {
        CL_HS_ACTIVE = 2'd0,
        CL_TO_LP     = 2'd1,
        CL_LP_IDLE   = 2'd2,
        CL_TO_HS     = 2'd3
    } cl_state_e;

    typedef struct packed {
        logic enter;
        logic wake;
    } cl_decision_t;

    typedef struct packed {
        logic lp_req;
        logic hs_ready;
    } cl_outputs_t;

    function automatic cl_outputs_t cl_decode(input cl_state_e st);
        cl_outputs_t o;
        o.lp_req   = (st == CL_TO_LP) || (st == CL_LP_IDLE);
        o.hs_ready = (st == CL_HS_ACTIVE);
        return o;
    endfunction

endpackage

// File: rtl/clk_lane_gate.sv
module clk_lane_gate
    import clk_lane_pkg::*;
#(
    parameter int TW = 8,
    parameter int BW = 16
) (
    input  logic          active,
    input  logic          mode_video,
    input  logic          hs_pending,
    input  logic [BW-1:0] blank_left,
    input  logic [TW-1:0] hs2lp,
    input  logic [TW-1:0] lp2hs,
    output cl_decision_t  dec
);
    localparam int SW = TW + 1;
    localparam int CW = (BW > SW) ? BW : SW;

    logic [CW-1:0] sum_x;
    logic [CW-1:0] blank_x;
    logic [CW-1:0] lp2hs_x;

    always_comb begin
        sum_x   = CW'(hs2lp) + CW'(lp2hs);
        blank_x = CW'(blank_left);
        lp2hs_x = CW'(lp2hs);
    end

    always_comb begin
        if (mode_video) begin
            dec.enter = active && (blank_x != '0) && (blank_x >= sum_x);
            dec.wake  = !active || (blank_x <= lp2hs_x);
        end else begin
            dec.enter = active && !hs_pending;
            dec.wake  = !active || hs_pending;
        end
    end
endmodule

// File: rtl/clk_lane_timer.sv
module clk_lane_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt <= TW'(1));
endmodule

// File: rtl/clk_lane_fsm.sv
module clk_lane_fsm
    import clk_lane_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  cl_decision_t dec,
    input  logic         tmr_done,
    output cl_state_e    state,
    output logic         tmr_load,
    output logic         sel_lp2hs
);
    cl_state_e nxt;

    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        sel_lp2hs = 1'b0;
        unique case (state)
            CL_HS_ACTIVE: if (dec.enter) begin
                nxt      = CL_TO_LP;
                tmr_load = 1'b1;
            end
            CL_TO_LP: if (tmr_done) nxt = CL_LP_IDLE;
            CL_LP_IDLE: if (dec.wake) begin
                nxt       = CL_TO_HS;
                tmr_load  = 1'b1;
                sel_lp2hs = 1'b1;
            end
            CL_TO_HS: if (tmr_done) nxt = CL_HS_ACTIVE;
            default: nxt = CL_HS_ACTIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CL_HS_ACTIVE;
        else     state <= nxt;
    end
endmodule

// File: rtl/clk_lane_lp_ctrl.sv
module clk_lane_lp_ctrl
    import clk_lane_pkg::*;
#(
    parameter int TW = 8,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_enable,
    input  logic          cfg_auto,
    input  logic [TW-1:0] cfg_hs2lp,
    input  logic [TW-1:0] cfg_lp2hs,
    input  logic          mode_video,
    input  logic          hs_pending,
    input  logic [BW-1:0] blank_left,
    output logic          lp_req,
    output logic          hs_ready
);
    cl_decision_t dec;
    cl_state_e    state;
    cl_outputs_t  outs;
    logic         tmr_load;
    logic         tmr_done;
    logic         sel_lp2hs;
    logic [TW-1:0] tmr_val;

    clk_lane_gate #(.TW(TW), .BW(BW)) u_gate (
        .active     (cfg_enable && cfg_auto),
        .mode_video (mode_video),
        .hs_pending (hs_pending),
        .blank_left (blank_left),
        .hs2lp      (cfg_hs2lp),
        .lp2hs      (cfg_lp2hs),
        .dec        (dec)
    );

    clk_lane_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .dec       (dec),
        .tmr_done  (tmr_done),
        .state     (state),
        .tmr_load  (tmr_load),
        .sel_lp2hs (sel_lp2hs)
    );

    assign tmr_val = sel_lp2hs ? cfg_lp2hs : cfg_hs2lp;

    clk_lane_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign outs     = cl_decode(state);
    assign lp_req   = outs.lp_req;
    assign hs_ready = outs.hs_ready;
endmodule

// File: rtl/clk_lane_lp_chk.sv
module clk_lane_lp_chk #(
    parameter int TW = 8,
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_enable,
    input logic          cfg_auto,
    input logic [TW-1:0] cfg_hs2lp,
    input logic [TW-1:0] cfg_lp2hs,
    input logic          mode_video,
    input logic          hs_pending,
    input logic [BW-1:0] blank_left,
    input logic          lp_req,
    input logic          hs_ready
);
    logic [BW+TW:0] need;
    assign need = (BW+TW+1)'(cfg_hs2lp) + (BW+TW+1)'(cfg_lp2hs);

    p_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(hs_ready && lp_req));

    p_disabled_stay_r2: assert property (@(posedge clk) disable iff (rst)
        (hs_ready && !(cfg_enable && cfg_auto)) |=> hs_ready);

    p_cmd_enter_r3: assert property (@(posedge clk) disable iff (rst)
        (hs_ready && cfg_enable && cfg_auto && !mode_video && !hs_pending) |=> lp_req);

    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (hs_ready && !mode_video && hs_pending) |=> hs_ready);

    p_video_short_r5: assert property (@(posedge clk) disable iff (rst)
        (hs_ready && mode_video && ((BW+TW+1)'(blank_left) < need)) |=> hs_ready);

    p_return_path_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(lp_req) |-> !hs_ready);

    p_ready_after_gap_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_ready) |-> !$past(lp_req));
endmodule

bind clk_lane_lp_ctrl clk_lane_lp_chk #(.TW(TW), .BW(BW)) u_chk (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_auto(cfg_auto),
    .cfg_hs2lp(cfg_hs2lp), .cfg_lp2hs(cfg_lp2hs), .mode_video(mode_video),
    .hs_pending(hs_pending), .blank_left(blank_left),
    .lp_req(lp_req), .hs_ready(hs_ready)
);

// File: tb/test_clk_lane_lp_ctrl.sv
`timescale 1ns/1ps
module test_clk_lane_lp_ctrl;
    localparam int TW = 8;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_enable = 1'b0;
    logic          cfg_auto = 1'b0;
    logic [TW-1:0] cfg_hs2lp = '0;
    logic [TW-1:0] cfg_lp2hs = '0;
    logic          mode_video = 1'b0;
    logic          hs_pending = 1'b1;
    logic [BW-1:0] blank_left = '0;
    logic          lp_req;
    logic          hs_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    clk_lane_lp_ctrl #(.TW(TW), .BW(BW)) i_clk_lane_lp_ctrl (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_auto(cfg_auto),
        .cfg_hs2lp(cfg_hs2lp), .cfg_lp2hs(cfg_lp2hs), .mode_video(mode_video),
        .hs_pending(hs_pending), .blank_left(blank_left),
        .lp_req(lp_req), .hs_ready(hs_ready)
    );

    // en, auto, video, pending, blank[16], hs2lp[8], lp2hs[8], expected lp_req
    localparam int NV = 12;
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 1'b1, 1'b0, 1'b0, 16'd0,   8'd3,   8'd2,   1'b1},
        {1'b1, 1'b1, 1'b0, 1'b1, 16'd0,   8'd3,   8'd2,   1'b0},
        {1'b0, 1'b1, 1'b0, 1'b0, 16'd0,   8'd3,   8'd2,   1'b0},
        {1'b1, 1'b0, 1'b0, 1'b0, 16'd0,   8'd3,   8'd2,   1'b0},
        {1'b1, 1'b1, 1'b1, 1'b1, 16'd10,  8'd3,   8'd4,   1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd7,   8'd3,   8'd4,   1'b1},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd6,   8'd3,   8'd4,   1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd0,   8'd0,   8'd0,   1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd1,   8'd0,   8'd0,   1'b1},
        {1'b0, 1'b1, 1'b1, 1'b0, 16'd100, 8'd3,   8'd4,   1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd509, 8'd255, 8'd255, 1'b0},
        {1'b1, 1'b1, 1'b1, 1'b0, 16'd510, 8'd255, 8'd255, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    initial begin
        // reset state (R1)
        do_reset();
        check("R1", hs_ready, 1'b1, "hs_ready after reset");
        check("R1", lp_req, 1'b0, "lp_req after reset");

        // entry decision table (R2 R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            do_reset();
            {cfg_enable, cfg_auto, mode_video, hs_pending, blank_left,
             cfg_hs2lp, cfg_lp2hs} = VEC[i][36:1];
            tick();
            check("R2/R3/R4/R5", lp_req, VEC[i][0], $sformatf("entry vector %0d", i));
        end

        // R6 and R7: command episode, hs2lp=3 lp2hs=2, wake raised during TO_LP
        do_reset();
        mode_video = 1'b0; cfg_enable = 1'b1; cfg_auto = 1'b1;
        cfg_hs2lp = 8'd3; cfg_lp2hs = 8'd2; hs_pending = 1'b0;
        tick();
        check("R6", hs_ready, 1'b0, "hs_ready low in TO_LP");
        hs_pending = 1'b1;
        tick(); tick(); tick();
        check("R6", lp_req, 1'b1, "lp still requested at cycle 4");
        tick();
        check("R7", lp_req, 1'b0, "lp_req dropped on wake");
        tick();
        check("R7", hs_ready, 1'b0, "hs_ready low second TO_HS cycle");
        tick();
        check("R7", hs_ready, 1'b1, "hs_ready after lp2hs");
        tick();
        check("R4", hs_ready, 1'b1, "held in HS while pending");

        // R6/R7 minimum one cycle with zero times
        do_reset();
        cfg_hs2lp = 8'd0; cfg_lp2hs = 8'd0; hs_pending = 1'b0;
        tick();
        hs_pending = 1'b1;
        tick();
        check("R6", lp_req, 1'b1, "rest after 1-cycle TO_LP");
        tick();
        check("R7", lp_req | hs_ready, 1'b0, "TO_HS lasts one cycle min");
        tick();
        check("R7", hs_ready, 1'b1, "ready after minimal TO_HS");

        // R8: video wake threshold, hs2lp=2 lp2hs=3
        do_reset();
        mode_video = 1'b1; hs_pending = 1'b0;
        cfg_hs2lp = 8'd2; cfg_lp2hs = 8'd3; blank_left = 16'd20;
        tick(); tick(); tick(); tick(); tick();
        check("R8", lp_req, 1'b1, "rest while blank_left large");
        blank_left = 16'd4;
        tick();
        check("R8", lp_req, 1'b1, "rest while blank_left > lp2hs");
        blank_left = 16'd3;
        tick();
        check("R8", lp_req, 1'b0, "return at blank_left == lp2hs");
        tick(); tick();
        check("R8", hs_ready, 1'b0, "TO_HS third cycle");
        tick();
        check("R8", hs_ready, 1'b1, "ready after lp2hs in video");
        check("R10", lp_req, 1'b0, "lp_req low when ready");

        // R9: enable cleared during rest, then stays in HS (R2)
        do_reset();
        mode_video = 1'b0; hs_pending = 1'b0;
        cfg_hs2lp = 8'd1; cfg_lp2hs = 8'd1;
        tick(); tick(); tick();
        check("R9", lp_req, 1'b1, "resting before disable");
        cfg_enable = 1'b0;
        tick();
        check("R9", lp_req | hs_ready, 1'b0, "return started on disable");
        tick();
        check("R9", hs_ready, 1'b1, "ready after forced return");
        tick(); tick();
        check("R2", hs_ready, 1'b1, "stays HS while disabled");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule